// File: doc/BRIEF.md
# DMA and Interrupt Bus Priority Arbiter

This block decides, on every clock, who owns the bus: one of three DMA channels or the CPU's pending interrupt request. It takes these inputs:
- the channel enables and channel requests
- the transfer size (byte or word)
- the block length
- a two-bit bandwidth share
- a raw interrupt request
- a mode bit that chooses whether interrupts outrank the DMA or queue behind it

It returns these outputs:
- a one-hot channel grant
- a one-cycle interrupt acknowledge
- one-cycle enable-clear pulses
- a busy flag that stays high while a byte, word or block transfer is in progress

A byte transfer holds the bus for 3 cycles and a word transfer for 5 cycles. A block repeats that unit a programmed number of times. While the mode bit is low, interrupts win at the next unit boundary. An interrupt taken this way also pulses clear for every enabled channel that still has work pending, so software must re-enable those channels. While the mode bit is high, an interrupt waits for the whole block to finish. New transfers then also win over the interrupt while the bus is idle.

Top module: `dmarb_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, grant, irq_ack, en_clr and busy are all zero.
- R2: When several enabled channels request at once, the lowest-numbered one is granted (channel 0 first, then 1, then 2).
- R3: A grant is issued only to a channel whose enable and request are both high. grant is never more than one-hot.
- R4: A granted channel keeps grant and busy for 3 cycles per unit when word_xfer=0 and 5 cycles per unit when word_xfer=1. The block is blk_len units back to back. There is at least one idle cycle before the next grant.
- R5: With dma_first=0, a pending interrupt is acknowledged at the next unit boundary, including in mid-block. The acknowledge comes at most 3 cycles after the request for bytes and at most 5 cycles for words. It comes 1 cycle after the request when the bus is idle.
- R6: With dma_first=0, an acknowledge pulses en_clr bit i for every enabled channel i that is requesting or is cut off mid-block. That channel then gets no grant until it is re-enabled.
- R7: With dma_first=1, an interrupt is acknowledged only when no transfer is in progress or at the end of the last unit of a block. An idle channel that is eligible to start wins over the interrupt. en_clr stays zero.
- R8: irq_ack is a one-cycle pulse and is never high on two consecutive cycles, even when the request is held. en_clr is nonzero only in a cycle where irq_ack is high.
- R9: A 2-bit slot counter is reset to 0 and advances by one every cycle. A transfer may start only on a cycle whose slot value is at most bw_share. 3 allows every cycle, and 0 allows one cycle in four.
- R10: A blk_len of 0 is treated as a block of one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_first | input | 1 | 1: DMA outranks interrupts; 0: interrupts outrank DMA |
| chan_en | input | NCH | Per-channel transfer enable |
| chan_req | input | NCH | Per-channel pending transfer request |
| word_xfer | input | 1 | 1: word unit (5 cycles), 0: byte unit (3 cycles) |
| blk_len | input | BLK_W | Units per block, sampled at start |
| bw_share | input | SHARE_W | Bandwidth share for starting transfers |
| irq_req | input | 1 | Raw CPU interrupt request |
| grant | output | NCH | One-hot channel grant (registered) |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| en_clr | output | NCH | Enable-clear pulses, issued with irq_ack |
| busy | output | 1 | A transfer is in progress |

## Verification
The embedded assertions check four properties on every cycle:
- a new grant only goes to a channel that was enabled and requesting
- grant never changes from one channel to another without idling first
- the beat counter stays within the word length
- acknowledges are single pulses, and clear pulses only come with acknowledges in interrupt-first mode

Some behaviour can only be shown by the bench's scenarios against its cycle-level model. This covers the priority order among channels, the exact 3/5-cycle unit lengths and block lengths, and the interrupt latency bound at mid-block boundaries. It also covers the deferral to block end in DMA-first mode, the slot pattern for each bandwidth share, and the fact that a cleared channel stays silent.

// File: rtl/dmarb_pkg.sv
`timescale 1ns/1ps
package dmarb_pkg;
  localparam int BYTE_CYC = 3;
  localparam int WORD_CYC = 5;
  localparam int BEAT_W   = $clog2(WORD_CYC + 1);

  function automatic logic [BEAT_W-1:0] unit_cycles(input logic is_word);
    return is_word ? BEAT_W'(WORD_CYC) : BEAT_W'(BYTE_CYC);
  endfunction
endpackage

// File: rtl/dmarb_slot_gate.sv
`timescale 1ns/1ps
module dmarb_slot_gate #(
  parameter int SHARE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHARE_W-1:0] share,
  output logic               slot_ok
);
  logic [SHARE_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_q + 1'b1;
  end

  // a start is allowed while the rotating slot is inside the share window
  assign slot_ok = (slot_q <= share);
endmodule

// File: rtl/dmarb_pick.sv
`timescale 1ns/1ps
module dmarb_pick #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] cand,
  output logic [NCH-1:0] win
);
  // fixed priority: lower index wins
  for (genvar i = 0; i < NCH; i++) begin : g_prio
    if (i == 0) begin : g_first
      assign win[i] = cand[i];
    end else begin : g_rest
      assign win[i] = cand[i] & ~(|cand[i-1:0]);
    end
  end
endmodule

// File: rtl/dmarb_xfer_ctr.sv
`timescale 1ns/1ps
module dmarb_xfer_ctr
  import dmarb_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             word,
  input  logic [BLK_W-1:0] len,
  input  logic             stop,
  output logic             active,
  output logic             beat_end,
  output logic             last_beat
);
  logic [BEAT_W-1:0] beat_q;
  logic [BLK_W-1:0]  blk_q;
  logic              word_q;
  logic              act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      blk_q  <= '0;
      word_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (start) begin
      act_q  <= 1'b1;
      word_q <= word;
      beat_q <= unit_cycles(word);
      blk_q  <= (len == '0) ? BLK_W'(1) : len;
    end else if (act_q) begin
      if (beat_q == BEAT_W'(1)) begin
        if (blk_q == BLK_W'(1) || stop) begin
          act_q  <= 1'b0;
          beat_q <= '0;
          blk_q  <= '0;
        end else begin
          beat_q <= unit_cycles(word_q);
          blk_q  <= blk_q - 1'b1;
        end
      end else begin
        beat_q <= beat_q - 1'b1;
      end
    end
  end

  assign active    = act_q;
  assign beat_end  = act_q && (beat_q == BEAT_W'(1));
  assign last_beat = (blk_q == BLK_W'(1));

  // R4
  beat_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (beat_q != '0 && beat_q <= BEAT_W'(WORD_CYC)));
  // R4
  block_live_chk: assert property (@(posedge clk) disable iff (rst)
    act_q |-> blk_q != '0);
endmodule

// File: rtl/dmarb_top.sv
`timescale 1ns/1ps
module dmarb_top
  import dmarb_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int BLK_W   = 8,
  parameter int SHARE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dma_first,
  input  logic [NCH-1:0]     chan_en,
  input  logic [NCH-1:0]     chan_req,
  input  logic               word_xfer,
  input  logic [BLK_W-1:0]   blk_len,
  input  logic [SHARE_W-1:0] bw_share,
  input  logic               irq_req,
  output logic [NCH-1:0]     grant,
  output logic               irq_ack,
  output logic [NCH-1:0]     en_clr,
  output logic               busy
);
  logic [NCH-1:0] grant_q, clr_q, elig, pick, grant_d, clr_d;
  logic ack_q, slot_ok, active, beat_end, last_beat;
  logic start, take_irq, irq_ok, can_start;

  dmarb_slot_gate #(.SHARE_W(SHARE_W)) u_slot (
    .clk(clk), .rst(rst), .share(bw_share), .slot_ok(slot_ok)
  );

  dmarb_pick #(.NCH(NCH)) u_pick (.cand(elig), .win(pick));

  dmarb_xfer_ctr #(.BLK_W(BLK_W)) u_ctr (
    .clk(clk), .rst(rst), .start(start), .word(word_xfer), .len(blk_len),
    .stop(take_irq), .active(active), .beat_end(beat_end), .last_beat(last_beat)
  );

  always_comb begin
    // a channel being cleared this cycle cannot be picked
    elig      = chan_en & chan_req & ~clr_q;
    can_start = slot_ok && (|pick);
    irq_ok    = irq_req && !ack_q;
    take_irq  = 1'b0;
    start     = 1'b0;
    if (active) begin
      take_irq = beat_end && irq_ok && (!dma_first || last_beat);
    end else begin
      take_irq = irq_ok && (!dma_first || !can_start);
      start    = !take_irq && can_start;
    end
    clr_d = '0;
    if (take_irq && !dma_first)
      clr_d = chan_en & (chan_req | ((active && !last_beat) ? grant_q : '0));
    grant_d = grant_q;
    if (start)
      grant_d = pick;
    else if (beat_end && (last_beat || take_irq))
      grant_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      clr_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      clr_q   <= clr_d;
      ack_q   <= take_irq;
    end
  end

  assign grant  = grant_q;
  assign irq_ack = ack_q;
  assign en_clr = clr_q;
  assign busy   = active;

  // R3
  grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> ((grant & $past(chan_en & chan_req)) == grant && grant != '0));
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && $past(grant) != '0) |-> grant == $past(grant));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
  // R8
  clr_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (en_clr != '0) |-> irq_ack);
  // R7
  dma_first_noclr_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && $past(dma_first)) |-> en_clr == '0);
endmodule

// File: tb/sim_dmarb_top.sv
`timescale 1ns/1ps
module sim_dmarb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       mode = 1'b0, word = 1'b0, irq = 1'b0;
  logic [2:0] en_reg = 3'b000, req = 3'b000;
  logic [7:0] blen = 8'd1;
  logic [1:0] bw = 2'd3;
  logic [2:0] grant, en_clr;
  logic       irq_ack, busy;

  dmarb_top u0 (
    .clk(clk), .rst(rst), .dma_first(mode), .chan_en(en_reg), .chan_req(req),
    .word_xfer(word), .blk_len(blen), .bw_share(bw), .irq_req(irq),
    .grant(grant), .irq_ack(irq_ack), .en_clr(en_clr), .busy(busy)
  );

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit auto_drop = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: elapsed-cycle count against total block cycles
  int mg = -1, mel = 0, mtot = 0, msz = 3, mslot = 0, pick;
  logic m_ack = 1'b0, n_ack;
  logic [2:0] m_clr = 3'b000, n_clr;
  bit bnd, lst, irq_ok;

  always @(posedge clk) begin
    if (rst) begin
      mg = -1; m_ack = 1'b0; m_clr = 3'b000; mslot = 0;
    end else begin
      n_ack = 1'b0; n_clr = 3'b000;
      irq_ok = irq && !m_ack;
      if (mg >= 0) begin
        mel++;
        bnd = (mel % msz) == 0;
        lst = (mel == mtot);
        if (bnd && irq_ok && (!mode || lst)) begin
          n_ack = 1'b1;
          if (!mode) n_clr = en_reg & (req | (lst ? 3'b000 : 3'(1 << mg)));
          mg = -1;
        end else if (lst) begin
          mg = -1;
        end
      end else begin
        pick = -1;
        if (mslot <= int'(bw))
          for (int i = 2; i >= 0; i--)
            if (en_reg[i] && req[i] && !m_clr[i]) pick = i;
        if (irq_ok && (!mode || pick < 0)) begin
          n_ack = 1'b1;
          if (!mode) n_clr = en_reg & req;
        end else if (pick >= 0) begin
          mg = pick; mel = 0; msz = word ? 5 : 3;
          mtot = msz * ((blen == 0) ? 1 : int'(blen));
        end
      end
      m_ack = n_ack; m_clr = n_clr;
      mslot = (mslot + 1) % 4;
    end
  end

  int run = 0, last_run = 0, ack_seen = 0, ack_cyc = 0, ack_run = 0;
  logic [2:0] ack_clr = 3'b000;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(grant == ((mg < 0) ? 3'b000 : 3'(1 << mg)), {cur_req, " grant"}, int'(grant),
          (mg < 0) ? 0 : (1 << mg));
      chk(irq_ack == m_ack, {cur_req, " irq_ack"}, int'(irq_ack), int'(m_ack));
      chk(en_clr == m_clr, {cur_req, " en_clr"}, int'(en_clr), int'(m_clr));
      chk(busy == (mg >= 0), {cur_req, " busy"}, int'(busy), int'(mg >= 0));
    end
    if (busy) run++;
    else if (run > 0) begin last_run = run; run = 0; end
    if (irq_ack) begin
      ack_seen++; ack_cyc = cyc; ack_clr = en_clr; ack_run = last_run;
      if (auto_drop) irq = 1'b0;
    end
    en_reg = en_reg & ~en_clr;
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic wait_busy(); while (!busy) step(); endtask
  task automatic wait_idle(); while (busy) step(); endtask
  task automatic wait_ack(); int s = ack_seen; while (ack_seen == s) step(); endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL WD run did not finish actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int t0, lat, base;
    repeat (3) step();
    // R1 state under reset
    chk(grant == 3'b000 && en_clr == 3'b000, "R1 reset outputs", int'({grant, en_clr}), 0);
    chk(!irq_ack && !busy, "R1 reset flags", int'({irq_ack, busy}), 0);
    rst = 1'b0;
    step();
    chk(!busy && grant == 3'b000, "R1 first cycle", int'(grant), 0);

    cur_req = "R2";
    en_reg = 3'b111; req = 3'b111;
    wait_busy();
    chk(grant == 3'b001, "R2 ch0 first", int'(grant), 1);
    req = 3'b110;
    wait_idle(); wait_busy();
    chk(grant == 3'b010, "R2 ch1 next", int'(grant), 2);
    req = 3'b000; wait_idle();

    cur_req = "R4";
    en_reg = 3'b010; req = 3'b010; word = 1'b1; blen = 8'd3;
    wait_busy(); req = 3'b000; wait_idle();
    chk(last_run == 15, "R4 word block length", last_run, 15);
    word = 1'b0; en_reg = 3'b100; req = 3'b100; blen = 8'd2;
    wait_busy(); req = 3'b000; wait_idle();
    chk(last_run == 6, "R4 byte block length", last_run, 6);

    cur_req = "R5";
    en_reg = 3'b011; req = 3'b010; word = 1'b1; blen = 8'd4; mode = 1'b0;
    wait_busy(); step(); step();
    irq = 1'b1; t0 = cyc;
    wait_ack();
    lat = ack_cyc - t0;
    chk(lat >= 1 && lat <= 5, "R5 word latency", lat, 5);
    chk(ack_clr == 3'b010, "R6 clear of cut block", int'(ack_clr), 2);
    step();
    chk(en_reg == 3'b001, "R6 enable left", int'(en_reg), 1);
    repeat (6) step();
    chk(!busy && grant == 3'b000, "R6 no regrant", int'(grant), 0);
    req = 3'b000;

    en_reg = 3'b100; req = 3'b100; word = 1'b0; blen = 8'd5;
    wait_busy(); step();
    irq = 1'b1; t0 = cyc;
    wait_ack();
    lat = ack_cyc - t0;
    chk(lat >= 1 && lat <= 3, "R5 byte latency", lat, 3);
    chk(ack_clr == 3'b100, "R6 byte clear", int'(ack_clr), 4);
    req = 3'b000; step();
    irq = 1'b1; t0 = cyc; wait_ack();
    chk(ack_cyc - t0 == 1, "R5 idle latency", ack_cyc - t0, 1);

    cur_req = "R7";
    mode = 1'b1; en_reg = 3'b100; req = 3'b100; blen = 8'd3;
    wait_busy(); step();
    irq = 1'b1; req = 3'b000;
    wait_ack();
    chk(ack_run == 9, "R7 ack after whole block", ack_run, 9);
    chk(ack_clr == 3'b000, "R7 no clear", int'(ack_clr), 0);
    chk(en_reg == 3'b100, "R7 enable kept", int'(en_reg), 4);
    en_reg = 3'b001; req = 3'b001; blen = 8'd1; irq = 1'b1;
    wait_ack(); req = 3'b000; wait_idle(); repeat (2) step();
    mode = 1'b0;

    cur_req = "R9";
    en_reg = 3'b001; req = 3'b001; bw = 2'd0;
    repeat (40) step();
    bw = 2'd1; repeat (24) step();
    bw = 2'd2; repeat (24) step();
    req = 3'b000; wait_idle(); bw = 2'd3;

    cur_req = "R10";
    blen = 8'd0; en_reg = 3'b010; req = 3'b010;
    wait_busy(); req = 3'b000; wait_idle();
    chk(last_run == 3, "R10 zero length", last_run, 3);
    blen = 8'd1;

    cur_req = "R8";
    auto_drop = 1'b0; irq = 1'b1; step(); base = ack_seen;
    repeat (6) step();
    chk(ack_seen - base == 3, "R8 held request pulses", ack_seen - base, 3);
    irq = 1'b0; auto_drop = 1'b1; repeat (2) step();

    cur_req = "R3";
    en_reg = 3'b000; req = 3'b111;
    repeat (10) step();
    chk(!busy && grant == 3'b000, "R3 disabled never granted", int'(grant), 0);
    en_reg = 3'b100; wait_busy();
    chk(grant == 3'b100, "R3 enabled granted", int'(grant), 4);
    req = 3'b000; wait_idle(); repeat (3) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule